// File: doc/BRIEF.md
# Elastic-Store Digital Jitter Attenuator

The block absorbs phase wander on a serial bit stream. Incoming bits arrive with a write strobe whose timing jitters. They go into a bit-wide elastic store. A digitally controlled oscillator, built as a phase accumulator on the fast master clock, produces a smoothed read strobe that drains the store at the long-term average input rate. A proportional-plus-integral loop filter sets the oscillator increment. The filter input is the store's fill error measured against half depth, so in steady state the block adds a fixed latency of half the selected depth.

The depth, the loop bandwidth and the line-rate family are selectable. An optional guard mode forces the read rate one step faster when the store nears full, and one step slower when it nears empty. Overflow and underflow are latched in sticky flags, and either event re-centres the store. A bypass mode routes the input bit and strobe straight to the outputs.

Top module: `jitter_atten`

## Requirements
- R1: `depth_sel_i` selects the store depth: 0 gives 32, 1 gives 64, and 2 or 3 give 128 bits. After a re-centre, the k-th read returns the bit of write number k minus half the depth, with both counts taken from the re-centre.
- R2: Reads are paced only by the phase accumulator. Its nominal step `NOM_INC` out of 2^`ACC_W` gives one read strobe per 2^`ACC_W`/`NOM_INC` master clocks, and the fill-error trim keeps this pace on average.
- R3: A write that arrives when the fill equals the depth, with no read in the same cycle, sets `ovf_o` on the next clock and re-centres the store.
- R4: A read attempted when the fill is zero sets `udf_o` on the next clock and re-centres the store.
- R5: Both flags are sticky. A high `clr_ovf_i` or `clr_udf_i` clears its flag on the next clock, and a new event in the same cycle wins over the clear.
- R6: The store re-centres to half the depth on reset, when the depth select changes, after an overflow or underflow, and while bypassed. No read strobe is issued in a re-centre cycle.
- R7: When `limit_en_i` is high and the fill is within the guard margin (2, 3 or 4 bits for depth 32, 64 or 128) of full or of empty, the step becomes `NOM_INC`+`LIMIT_STEP` near full or `NOM_INC`-`LIMIT_STEP` near empty. The integrator is frozen while the guard is active.
- R8: `bw_sel_i` (1 = wide) and `e1_mode_i` (1 = E1 rate family) pick one of four shift-gain pairs. Under nominal-rate writes with up to ±3 master clocks of sinusoidal phase wander, neither flag sets for any combination.
- R9: While `bypass_i` is high, `rd_bit_o` equals `wr_bit_i` and `rd_stb_o` equals `wr_stb_i` in the same cycle.
- R10: During reset, `rd_stb_o`, `ovf_o` and `udf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_bit_i | input | 1 | Incoming data bit |
| wr_stb_i | input | 1 | One-cycle write strobe for `wr_bit_i` |
| depth_sel_i | input | 2 | Store depth select |
| bw_sel_i | input | 1 | Loop bandwidth select, 1 = wide |
| e1_mode_i | input | 1 | Rate family select, 1 = E1, 0 = T1/J1 |
| limit_en_i | input | 1 | Enables forced rate steps near full or empty |
| bypass_i | input | 1 | Routes input straight to output |
| clr_ovf_i | input | 1 | Write-one-to-clear for the overflow flag |
| clr_udf_i | input | 1 | Write-one-to-clear for the underflow flag |
| rd_bit_o | output | 1 | De-jittered data bit |
| rd_stb_o | output | 1 | One-cycle read strobe qualifying `rd_bit_o` |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its defaults: a 16-bit accumulator, a nominal step of 8192 and a guard step of 4096. This places the nominal read every 8 master clocks, so a write stream with a few clocks of wander keeps the fill within a bit or two of centre at every depth. The guard step moves the read spacing to about 5 clocks near full and 16 near empty. Those spacings sit well apart from the trimmed nominal spacing of about 8, so the exact guard margin of the 32-bit depth can be resolved from the output strobe spacing alone. All three depths, plus the alias code 3, fit inside a few thousand cycles each, including a depth change made without a reset.

// File: rtl/jitter_atten_pkg.sv
package jitter_atten_pkg;
  localparam int MIN_LG = 5;
  localparam int MAX_AW = MIN_LG + 2;

  typedef struct packed {
    logic [2:0] kp;
    logic [2:0] ki;
  } gains_t;

  function automatic logic [MAX_AW:0] depth_of(input logic [1:0] sel);
    logic [MAX_AW:0] d;
    d = '0;
    case (sel)
      2'd0:    d[MIN_LG]   = 1'b1;
      2'd1:    d[MIN_LG+1] = 1'b1;
      default: d[MIN_LG+2] = 1'b1;
    endcase
    return d;
  endfunction

  // guard margin grows by one bit per depth doubling
  function automatic logic [MAX_AW:0] thr_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return (MAX_AW+1)'(2);
      2'd1:    return (MAX_AW+1)'(3);
      default: return (MAX_AW+1)'(4);
    endcase
  endfunction

  function automatic gains_t gains_of(input logic e1, input logic wide);
    case ({e1, wide})
      2'b00:   return '{kp: 3'd3, ki: 3'd3};
      2'b01:   return '{kp: 3'd5, ki: 3'd1};
      2'b10:   return '{kp: 3'd2, ki: 3'd4};
      default: return '{kp: 3'd4, ki: 3'd2};
    endcase
  endfunction
endpackage

// File: rtl/ja_fifo.sv
module ja_fifo
  import jitter_atten_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      depth_sel_i,
  input  logic            resync_i,
  input  logic            wr_i,
  input  logic            wr_bit_i,
  input  logic            rd_i,
  output logic            rd_bit_o,
  output logic [MAX_AW:0] fill_o
);
  localparam int AW   = MAX_AW;
  localparam int SLOTS = 1 << AW;

  logic            mem_q [SLOTS];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q, mask;
  logic [AW:0]     fill_q, depth, half;

  assign depth    = depth_of(depth_sel_i);
  assign half     = depth >> 1;
  assign mask     = depth[AW-1:0] - AW'(1);
  assign rd_bit_o = mem_q[rd_ptr_q];
  assign fill_o   = fill_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wr_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= AW'(1 << (MIN_LG-1));
      rd_ptr_q <= '0;
      fill_q   <= (AW+1)'(1 << (MIN_LG-1));
    end else if (resync_i) begin
      wr_ptr_q <= wr_ptr_q & mask;
      rd_ptr_q <= (wr_ptr_q - half[AW-1:0]) & mask;
      fill_q   <= half;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q + AW'(1)) & mask;
      if (rd_i) rd_ptr_q <= (rd_ptr_q + AW'(1)) & mask;
      fill_q <= fill_q + (AW+1)'(wr_i) - (AW+1)'(rd_i);
    end
  end

  // R1: fill never exceeds the selected depth outside a re-centre
  a_r1_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resync_i |-> fill_q <= depth);

  // R6: re-centre lands on half depth
  a_r6_recentre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> fill_q == $past(half));
endmodule

// File: rtl/ja_dpll.sv
module ja_dpll
  import jitter_atten_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int NOM_INC    = 8192,
  parameter int LIMIT_STEP = 4096,
  parameter int INT_W      = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      depth_sel_i,
  input  logic            bw_sel_i,
  input  logic            e1_mode_i,
  input  logic            limit_en_i,
  input  logic            resync_i,
  input  logic [MAX_AW:0] fill_i,
  output logic            tick_o
);
  localparam int AW      = MAX_AW;
  localparam int EW      = AW + 2;
  localparam int INC_TOP = (1 << ACC_W) - 1;

  logic [AW:0]             depth, half, thr;
  logic signed [EW-1:0]    err;
  logic                    near_full, near_empty, guard_act;
  gains_t                  g;
  logic signed [INT_W-1:0] integ_q;
  logic signed [31:0]      trim, inc_s;
  logic [ACC_W-1:0]        inc, acc_q;
  logic [ACC_W:0]          sum;

  assign depth      = depth_of(depth_sel_i);
  assign half       = depth >> 1;
  assign thr        = thr_of(depth_sel_i);
  assign g          = gains_of(e1_mode_i, bw_sel_i);
  assign err        = $signed({1'b0, fill_i}) - $signed({1'b0, half});
  assign near_full  = fill_i >= (depth - thr);
  assign near_empty = fill_i <= thr;
  assign guard_act  = limit_en_i & (near_full | near_empty);

  always_comb begin
    trim  = ($signed(32'(err)) <<< g.kp) + 32'(integ_q >>> g.ki);
    inc_s = 32'(NOM_INC) + trim;
    if (limit_en_i && near_full)       inc_s = 32'(NOM_INC + LIMIT_STEP);
    else if (limit_en_i && near_empty) inc_s = 32'(NOM_INC - LIMIT_STEP);
    if (inc_s < 32'sd1)                inc = ACC_W'(1);
    else if (inc_s > 32'(INC_TOP))     inc = ACC_W'(INC_TOP);
    else                               inc = inc_s[ACC_W-1:0];
  end

  assign sum    = {1'b0, acc_q} + {1'b0, inc};
  assign tick_o = sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      integ_q <= '0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (resync_i)                  integ_q <= '0;
      else if (tick_o && !guard_act) integ_q <= integ_q + INT_W'(err);
    end
  end

  // R7: no integration while the guard forces the rate
  a_r7_integ_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_en_i && (near_full || near_empty) && !resync_i) |=> $stable(integ_q));
endmodule

// File: rtl/jitter_atten.sv
module jitter_atten
  import jitter_atten_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int NOM_INC    = 8192,
  parameter int LIMIT_STEP = 4096,
  parameter int INT_W      = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_bit_i,
  input  logic       wr_stb_i,
  input  logic [1:0] depth_sel_i,
  input  logic       bw_sel_i,
  input  logic       e1_mode_i,
  input  logic       limit_en_i,
  input  logic       bypass_i,
  input  logic       clr_ovf_i,
  input  logic       clr_udf_i,
  output logic       rd_bit_o,
  output logic       rd_stb_o,
  output logic       ovf_o,
  output logic       udf_o
);
  logic [MAX_AW:0] fill, depth;
  logic [1:0]      depth_q;
  logic            tick, rd_req, wr_req, ovf_ev, udf_ev, depth_chg, resync;
  logic            fifo_wr, fifo_rd, fifo_bit;
  logic            rd_stb_q, rd_bit_q, ovf_q, udf_q;

  assign depth     = depth_of(depth_sel_i);
  assign rd_req    = tick & ~bypass_i;
  assign wr_req    = wr_stb_i & ~bypass_i;
  assign ovf_ev    = wr_req & ~rd_req & (fill == depth);
  assign udf_ev    = rd_req & (fill == '0);
  assign depth_chg = depth_sel_i != depth_q;
  assign resync    = depth_chg | ovf_ev | udf_ev | bypass_i;
  assign fifo_wr   = wr_req & ~resync;
  assign fifo_rd   = rd_req & ~resync;

  ja_fifo u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .depth_sel_i (depth_sel_i),
    .resync_i    (resync),
    .wr_i        (fifo_wr),
    .wr_bit_i    (wr_bit_i),
    .rd_i        (fifo_rd),
    .rd_bit_o    (fifo_bit),
    .fill_o      (fill)
  );

  ja_dpll #(
    .ACC_W      (ACC_W),
    .NOM_INC    (NOM_INC),
    .LIMIT_STEP (LIMIT_STEP),
    .INT_W      (INT_W)
  ) u_dpll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .depth_sel_i (depth_sel_i),
    .bw_sel_i    (bw_sel_i),
    .e1_mode_i   (e1_mode_i),
    .limit_en_i  (limit_en_i),
    .resync_i    (resync),
    .fill_i      (fill),
    .tick_o      (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q  <= 2'd0;
      rd_stb_q <= 1'b0;
      rd_bit_q <= 1'b0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      depth_q  <= depth_sel_i;
      rd_stb_q <= fifo_rd;
      if (fifo_rd) rd_bit_q <= fifo_bit;
      ovf_q <= ovf_ev | (ovf_q & ~clr_ovf_i);
      udf_q <= udf_ev | (udf_q & ~clr_udf_i);
    end
  end

  assign rd_bit_o = bypass_i ? wr_bit_i : rd_bit_q;
  assign rd_stb_o = bypass_i ? wr_stb_i : rd_stb_q;
  assign ovf_o    = ovf_q;
  assign udf_o    = udf_q;

  a_r3_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_ev |=> ovf_o);

  a_r4_udf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_ev |=> udf_o);

  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);

  a_r5_udf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_o && !clr_udf_i) |=> udf_o);
endmodule

// File: tb/jitter_atten_test.sv
module jitter_atten_test;
  localparam int NW   = 400;
  localparam int ROWS = 5;
  // row: depth select, bandwidth, E1, wander amplitude, reset first, expected delay
  localparam int T_SEL  [ROWS] = '{0, 1, 2, 3, 1};
  localparam int T_BW   [ROWS] = '{0, 1, 0, 1, 1};
  localparam int T_E1   [ROWS] = '{0, 0, 1, 1, 0};
  localparam int T_AMP  [ROWS] = '{2, 3, 3, 2, 3};
  localparam int T_RST  [ROWS] = '{1, 1, 1, 1, 0};
  localparam int T_HALF [ROWS] = '{16, 32, 64, 64, 32};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_bit = 1'b0, wr_stb = 1'b0, bw = 1'b0, e1 = 1'b0, lim = 1'b0;
  logic byp = 1'b0, clr_ovf = 1'b0, clr_udf = 1'b0;
  logic [1:0] dsel = 2'd0;
  logic rd_bit, rd_stb, ovf, udf;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic bits [NW];
  int off_tab [32];
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  jitter_atten uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_bit_i(wr_bit), .wr_stb_i(wr_stb),
    .depth_sel_i(dsel), .bw_sel_i(bw), .e1_mode_i(e1), .limit_en_i(lim),
    .bypass_i(byp), .clr_ovf_i(clr_ovf), .clr_udf_i(clr_udf),
    .rd_bit_o(rd_bit), .rd_stb_o(rd_stb), .ovf_o(ovf), .udf_o(udf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_to(input logic [1:0] sel);
    wr_stb = 1'b0; byp = 1'b0; clr_ovf = 1'b0; clr_udf = 1'b0;
    rst_n = 1'b0; dsel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_row(input int r);
    int wr_n, rd_n, cmp, mism, next_t, half, span;
    half = T_HALF[r];
    bw = T_BW[r][0]; e1 = T_E1[r][0]; lim = 1'b0;
    if (T_RST[r] != 0) reset_to(T_SEL[r][1:0]);
    else begin
      dsel = T_SEL[r][1:0];
      @(negedge clk);
    end
    for (int i = 0; i < 32; i++)
      off_tab[i] = $rtoi(real'(T_AMP[r]) * $sin(6.2831853 * real'(i) / 32.0));
    for (int i = 0; i < NW; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bits[i] = lf[0];
    end
    wr_n = 0; rd_n = 0; cmp = 0; mism = 0;
    next_t = 10 + off_tab[0];
    span = NW * 8 + 12;
    for (int cyc = 0; cyc < span; cyc++) begin
      if (rd_stb) begin
        if (rd_n >= half) begin
          cmp++;
          if (rd_bit !== bits[rd_n - half]) mism++;
        end
        rd_n++;
      end
      if (wr_n < NW && cyc == next_t) begin
        wr_stb = 1'b1; wr_bit = bits[wr_n]; wr_n++;
        next_t = 10 + 8 * wr_n + off_tab[wr_n % 32];
      end else wr_stb = 1'b0;
      @(negedge clk);
    end
    wr_stb = 1'b0;
    // R1 (R6 for the row entered by a depth change): data delayed by half depth
    check(mism == 0, (T_RST[r] != 0) ? "R1" : "R6", $sformatf("row %0d mismatches", r), mism, 0);
    check(cmp >= NW - half - 4, "R1", $sformatf("row %0d compared bits", r), cmp, NW - half);
    check(rd_n >= span / 8 - 6 && rd_n <= span / 8 + 6, "R2",
          $sformatf("row %0d read count", r), rd_n, span / 8);
    check(ovf == 1'b0, "R8", $sformatf("row %0d overflow flag", r), int'(ovf), 0);
    check(udf == 1'b0, "R8", $sformatf("row %0d underflow flag", r), int'(udf), 0);
  endtask

  initial begin
    int fillm, t_prev, f_prev, nstb, max_gap, gap;
    bit wrote;
    // R10: reset state
    @(negedge clk);
    check(rd_stb == 1'b0, "R10", "rd_stb in reset", int'(rd_stb), 0);
    check(ovf == 1'b0, "R10", "ovf in reset", int'(ovf), 0);
    check(udf == 1'b0, "R10", "udf in reset", int'(udf), 0);

    for (int r = 0; r < ROWS; r++) run_row(r);

    // R7 near empty: no writes, spacing at fill 3 vs fill 2 (depth 32, margin 2)
    bw = 1'b0; e1 = 1'b0;
    reset_to(2'd0);
    lim = 1'b1;
    fillm = 16; t_prev = -1; f_prev = 99;
    for (int cyc = 0; cyc < 800 && !udf; cyc++) begin
      if (rd_stb) begin
        if (t_prev >= 0 && f_prev == 3)
          check(cyc - t_prev <= 10, "R7", "spacing at fill 3 (outside margin)", cyc - t_prev, 8);
        if (t_prev >= 0 && f_prev == 2)
          check(cyc - t_prev >= 14, "R7", "spacing at fill 2 (inside margin)", cyc - t_prev, 16);
        fillm--; t_prev = cyc; f_prev = fillm;
      end
      @(negedge clk);
    end
    // R4: the next read from empty latches the flag
    check(udf == 1'b1, "R4", "underflow flag after drain", int'(udf), 1);
    check(ovf == 1'b0, "R4", "overflow flag after drain", int'(ovf), 0);
    clr_udf = 1'b1; @(negedge clk); clr_udf = 1'b0;
    check(udf == 1'b0, "R5", "underflow flag after clear", int'(udf), 0);

    // R7 near full: keep fill at 30..31, read spacing must shrink
    reset_to(2'd0);
    lim = 1'b1;
    fillm = 16; wrote = 1'b0; nstb = 0; t_prev = -1; max_gap = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (wrote) fillm++;
      if (rd_stb) begin
        fillm--; nstb++;
        if (nstb > 6 && nstb <= 12) begin
          gap = cyc - t_prev;
          if (gap > max_gap) max_gap = gap;
        end
        t_prev = cyc;
      end
      wrote = (fillm < 31);
      wr_stb = wrote; wr_bit = 1'b1;
      @(negedge clk);
    end
    wr_stb = 1'b0;
    check(max_gap >= 1 && max_gap <= 6, "R7", "max spacing near full", max_gap, 6);
    check(ovf == 1'b0, "R7", "no overflow with guard", int'(ovf), 0);

    // R3: burst writes with guard off overflow the 32-bit store
    lim = 1'b0;
    reset_to(2'd0);
    for (int i = 0; i < 24; i++) begin
      wr_stb = 1'b1; wr_bit = 1'b0;
      @(negedge clk);
    end
    wr_stb = 1'b0;
    @(negedge clk);
    check(ovf == 1'b1, "R3", "overflow flag after burst", int'(ovf), 1);
    check(udf == 1'b0, "R3", "underflow flag after burst", int'(udf), 0);
    repeat (3) @(negedge clk);
    check(ovf == 1'b1, "R5", "overflow flag stays set", int'(ovf), 1);
    clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
    check(ovf == 1'b0, "R5", "overflow flag after clear", int'(ovf), 0);

    // R9: bypass passes bit and strobe in the same cycle
    byp = 1'b1; wr_bit = 1'b1; wr_stb = 1'b1; #1;
    check(rd_bit == 1'b1, "R9", "bypass bit high", int'(rd_bit), 1);
    check(rd_stb == 1'b1, "R9", "bypass strobe high", int'(rd_stb), 1);
    @(negedge clk);
    wr_bit = 1'b0; wr_stb = 1'b0; #1;
    check(rd_bit == 1'b0, "R9", "bypass bit low", int'(rd_bit), 0);
    check(rd_stb == 1'b0, "R9", "bypass strobe low", int'(rd_stb), 0);
    byp = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule